// File: doc/BRIEF.md
# SM3 Message Expansion Datapath

This block produces four new expanded message words of the SM3 hash per issued operation. Each operation takes three 128-bit operands, `op_x`, `op_y` and `op_z`, each made up of four 32-bit lanes, with lane 0 in bits [31:0]. A one-bit step select chooses between two partial expansion steps. The first step mixes the three operands and applies the P1 diffusion map to every lane. The second step folds a rotated operand into a previous first-step result and applies a correction to lane 3.

In the first step, lane 3 depends on the finished value of lane 0 from the same operation. That serial link sets the longest combinational path of the block. The result is registered, and a valid flag follows the input strobe by one clock.

Top module: `sm3_msg_expand`

## Requirements
- R1: P1(v) = v ^ rol(v,15) ^ rol(v,23), where rol is a 32-bit rotate left.
- R2: When `step_sel`=0 (first step), lanes i=0,1,2 of the result equal P1(x[i] ^ y[i] ^ rol(z[i+1],15)).
- R3: When `step_sel`=0, lane 3 equals P1(x[3] ^ y[3] ^ rol(q0,15)), where q0 is the final (post-P1) lane 0 of the same result.
- R4: When `step_sel`=1 (second step), lanes i=0,1,2 equal x[i] ^ y[i] ^ rol(z[i],7).
- R5: When `step_sel`=1, lane 3 equals x[3] ^ t3 ^ P1(rol(t0,15)), where t[i] = y[i] ^ rol(z[i],7).
- R6: `res_valid` is high exactly one cycle after `op_valid` is sampled high, and low otherwise.
- R7: After reset, `res_valid` is 0 and `res_data` is 0.
- R8: `res_data` is updated only when `op_valid` is high. With no strobe it holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operands valid strobe |
| step_sel | input | 1 | 0 = first step, 1 = second step |
| op_x | input | 128 | Operand x, four 32-bit lanes |
| op_y | input | 128 | Operand y, four 32-bit lanes |
| op_z | input | 128 | Operand z, four 32-bit lanes |
| res_valid | output | 1 | Result valid |
| res_data | output | 128 | Registered result, four lanes |

## Verification
Every result is due on the clock edge after the one that samples `op_valid`. The driver task pushes the expected vector into a queue at the moment it applies the operands. The monitor samples at the falling edge and pops one entry for each cycle in which `res_valid` is high, so every check lines up with that single register stage. Idle cycles between operations check that the output holds its value. Back-to-back issues check that results stay in order under a full-rate stream.

// File: rtl/sm3_exp_pkg.sv
package sm3_exp_pkg;
  parameter int WORD_W = 32;
  parameter int LANES  = 4;
  localparam int VEC_W = WORD_W * LANES;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [VEC_W-1:0]  vec_t;

  function automatic word_t rotl(input word_t v, input int unsigned s);
    rotl = (v << s) | (v >> (WORD_W - s));
  endfunction

  function automatic word_t perm_p1(input word_t v);
    perm_p1 = v ^ rotl(v, 15) ^ rotl(v, 23);
  endfunction

  function automatic word_t lane(input vec_t v, input int unsigned i);
    lane = v[i*WORD_W +: WORD_W];
  endfunction
endpackage

// File: rtl/sm3_step1.sv
module sm3_step1
  import sm3_exp_pkg::*;
(
  input  vec_t x,
  input  vec_t y,
  input  vec_t z,
  output vec_t res
);
  word_t pre [LANES];
  word_t fin [LANES];

  for (genvar i = 0; i < LANES - 1; i++) begin : g_lo
    assign pre[i] = lane(x, i) ^ lane(y, i) ^ rotl(lane(z, i + 1), 15);
  end
  // serial link: top lane waits on the finished lane 0
  assign pre[LANES-1] = lane(x, LANES-1) ^ lane(y, LANES-1) ^ rotl(fin[0], 15);

  for (genvar i = 0; i < LANES; i++) begin : g_p1
    assign fin[i] = perm_p1(pre[i]);
    assign res[i*WORD_W +: WORD_W] = fin[i];
  end
endmodule

// File: rtl/sm3_step2.sv
module sm3_step2
  import sm3_exp_pkg::*;
(
  input  vec_t x,
  input  vec_t y,
  input  vec_t z,
  output vec_t res
);
  word_t t [LANES];
  word_t fix;

  for (genvar i = 0; i < LANES; i++) begin : g_t
    assign t[i] = lane(y, i) ^ rotl(lane(z, i), 7);
  end
  assign fix = perm_p1(rotl(t[0], 15));

  for (genvar i = 0; i < LANES; i++) begin : g_r
    if (i == LANES - 1) begin : g_top
      assign res[i*WORD_W +: WORD_W] = lane(x, i) ^ t[i] ^ fix;
    end else begin : g_plain
      assign res[i*WORD_W +: WORD_W] = lane(x, i) ^ t[i];
    end
  end
endmodule

// File: rtl/sm3_msg_expand.sv
module sm3_msg_expand
  import sm3_exp_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic         step_sel,
  input  logic [127:0] op_x,
  input  logic [127:0] op_y,
  input  logic [127:0] op_z,
  output logic         res_valid,
  output logic [127:0] res_data
);
  vec_t s1_res, s2_res, nxt;
  logic load_ev;

  sm3_step1 u_s1 (.x(op_x), .y(op_y), .z(op_z), .res(s1_res));
  sm3_step2 u_s2 (.x(op_x), .y(op_y), .z(op_z), .res(s2_res));

  assign nxt     = step_sel ? s2_res : s1_res;
  assign load_ev = op_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= load_ev;
      if (load_ev) res_data <= nxt;
    end
  end

  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);
  // R6
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(res_data));
  // R3
  lane3_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !step_sel) |=> (res_data[127:96] ==
      perm_p1($past(op_x[127:96]) ^ $past(op_y[127:96]) ^ rotl(res_data[31:0], 15))));
  // R4
  s2_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && step_sel) |=> (res_data[31:0] ==
      ($past(op_x[31:0]) ^ $past(op_y[31:0]) ^ rotl($past(op_z[31:0]), 7))));
endmodule

// File: tb/tb_sm3_msg_expand.sv
module tb_sm3_msg_expand;
  logic clk = 0;
  logic rst_n = 0;
  logic op_valid = 0, step_sel = 0;
  logic [127:0] op_x = '0, op_y = '0, op_z = '0;
  logic res_valid;
  logic [127:0] res_data;
  int checks = 0, fails = 0;
  logic [127:0] expq [$];
  logic [127:0] last_exp = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sm3_msg_expand dut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .step_sel(step_sel),
    .op_x(op_x), .op_y(op_y), .op_z(op_z), .res_valid(res_valid), .res_data(res_data));

  function automatic logic [31:0] rl(logic [31:0] v, int s);
    logic [63:0] d = {v, v};
    return d[63-s -: 32];
  endfunction
  // R1
  function automatic logic [31:0] p1m(logic [31:0] v);
    return v ^ rl(v, 15) ^ rl(v, 23);
  endfunction

  function automatic logic [127:0] model(bit sel, logic [127:0] x, y, z);
    logic [31:0] r [4];
    logic [31:0] t [4];
    if (!sel) begin
      for (int i = 0; i < 3; i++) r[i] = p1m(x[32*i +: 32] ^ y[32*i +: 32] ^ rl(z[32*(i+1) +: 32], 15));
      r[3] = p1m(x[127:96] ^ y[127:96] ^ rl(r[0], 15));
    end else begin
      for (int i = 0; i < 4; i++) begin
        t[i] = y[32*i +: 32] ^ rl(z[32*i +: 32], 7);
        r[i] = x[32*i +: 32] ^ t[i];
      end
      r[3] = r[3] ^ p1m(rl(t[0], 15));
    end
    return {r[3], r[2], r[1], r[0]};
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic issue(bit sel, logic [127:0] x, y, z);
    @(posedge clk); #1;
    op_valid = 1; step_sel = sel; op_x = x; op_y = y; op_z = z;
    expq.push_back(model(sel, x, y, z));
  endtask

  task automatic idle(int n);
    @(posedge clk); #1; op_valid = 0;
    repeat (n - 1) @(posedge clk);
  endtask

  // monitor: negedge sampling
  always @(negedge clk) if (rst_n && !done) begin
    if (res_valid) begin
      if (expq.size() == 0) chk(0, "R6", {127'b0, res_valid}, 128'b0);
      else begin
        last_exp = expq.pop_front();
        chk(res_data === last_exp, "R2/R3/R4/R5", res_data, last_exp);
      end
    end else if (checks > 0) begin
      chk(res_data === last_exp, "R8 hold", res_data, last_exp);
    end
  end

  initial begin
    #500000;
    fails++; checks++;
    $display("FAIL watchdog act=hang exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R7
    chk(res_valid === 0 && res_data === '0, "R7", res_data, '0);
    rst_n = 1;
    // R2 R3 directed: only lane 0 of x set, others zero
    issue(0, 128'h1, '0, '0);
    idle(3);
    // R5 directed: only z lane 0 set
    issue(1, '0, '0, 128'h1);
    idle(2);
    // random, mixed, back-to-back
    for (int k = 0; k < 200; k++) begin
      issue(k[0] ^ k[3], {$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom});
      if (k % 7 == 0) idle(2);
    end
    idle(4);
    // R6: queue drained, valid low
    #3;
    chk(expq.size() == 0 && res_valid === 0, "R6", {127'b0, res_valid}, 128'b0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule